// File: doc/BRIEF.md
# Pulse-Triggered JK Storage Cell Emulator

This block reproduces, on a fast system clock, the behaviour of a pulse-triggered JK storage cell built from two cascaded latches. A slow "device clock" input is brought into the system clock domain through a small synchronizer. While the synchronized device clock is high, a front (master) stage responds to J and K, gated by the cell's own output. While it is low, a back (slave) stage copies the master. The output therefore changes only after the device clock falls.

The emulation keeps the side effect of this structure: when the output is 0, any single system cycle in which J is high during the high phase sets the master. The master then stays set until the next pulse, so the output becomes 1 after the fall even though J has already dropped. The same holds for K when the output is 1. Active-low preset and clear override everything at once, without waiting for a clock edge. Driving both low at the same time is flagged as an error.

Top module: `jkms_emu`

## Requirements
- R1: While reset is asserted and after it is released, `q_o`=0, `qn_o`=1 and `forbid_o`=0 until the first completed device-clock pulse or override.
- R2: While the synchronized device clock is low, changes on `j_i`/`k_i` leave the master unchanged. A later pulse with J=K=0 therefore leaves `q_o` at its old value.
- R3: While the synchronized device clock is high, `q_o` holds the value it had when the pulse began.
- R4: Each device-clock pulse, with J and K held over it, updates Q as follows: J=0,K=0 holds; J=0,K=1 gives 0; J=1,K=0 gives 1; J=1,K=1 inverts Q exactly once, however long the pulse lasts.
- R5: If Q=0 and J is high for even one system cycle of the high phase, Q becomes 1 after the fall. If Q=1 and K is high for one such cycle, Q becomes 0. K while Q=0, or J while Q=1, has no effect.
- R6: `pr_ni`=0 with `clr_ni`=1 gives `q_o`=1 and `qn_o`=0 combinationally, whatever J, K and CK are. The cell holds 1 after release.
- R7: `clr_ni`=0 with `pr_ni`=1 gives `q_o`=0 and `qn_o`=1 combinationally. The cell holds 0 after release.
- R8: `pr_ni`=`clr_ni`=0 gives `q_o`=`qn_o`=1 and `forbid_o`=1. After at least one system clock edge in that state, releasing both gives Q=0.
- R9: The device clock passes through SYNC_STAGES flops (default 2). After a falling CK input set up before edge e0, `q_o` changes after edge e(SYNC_STAGES) and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the emulator |
| j_i | input | 1 | J input |
| k_i | input | 1 | K input |
| ck_i | input | 1 | Device clock, asynchronous to clk_i |
| pr_ni | input | 1 | Active-low preset |
| clr_ni | input | 1 | Active-low clear |
| q_o | output | 1 | Cell output Q |
| qn_o | output | 1 | Complementary output |
| forbid_o | output | 1 | Preset and clear are both active |

## Verification
The hardest case to produce is a J or K that is high for a single system cycle, only inside the synchronized high phase, and low again before the fall. The bench places such glitches relative to the synchronizer latency, both in directed cases and at random within pulses. A bench function predicts the caught value from the Q held at the start of the pulse. Long pulses with J=K=1 confirm that the feedback cannot toggle the cell twice.

// File: rtl/jkms_pkg.sv
package jkms_pkg;

  typedef enum logic [1:0] {
    FRC_NONE = 2'd0,
    FRC_SET  = 2'd1,
    FRC_CLR  = 2'd2,
    FRC_BOTH = 2'd3
  } frc_e;

  // decode of the active-low override pins
  function automatic frc_e frc_decode(input logic pr_n, input logic clr_n);
    case ({pr_n, clr_n})
      2'b01:   return FRC_SET;
      2'b10:   return FRC_CLR;
      2'b00:   return FRC_BOTH;
      default: return FRC_NONE;
    endcase
  endfunction

  // gated set/reset of the front latch: set only when the fed-back Q is 0,
  // reset only when it is 1
  function automatic logic master_next(input logic m, input logic j,
                                       input logic k, input logic q_fb);
    if (j && !q_fb) return 1'b1;
    if (k && q_fb)  return 1'b0;
    return m;
  endfunction

endpackage

// File: rtl/jkms_ck_sync.sv
module jkms_ck_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ck_i,
  output logic ck_s_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= 1'b0;
    else         chain_q[0] <= ck_i;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b0;
      else         chain_q[g] <= chain_q[g-1];
    end

    AST_SYNC_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> chain_q[g] == $past(chain_q[g-1])); // R9
  end

  assign ck_s_o = chain_q[LAST];
endmodule

// File: rtl/jkms_master.sv
module jkms_master
  import jkms_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ph_hi_i,
  input  logic j_i,
  input  logic k_i,
  input  logic q_fb_i,
  input  frc_e frc_i,
  output logic m_o
);
  logic m_q;
  logic frc_act;

  assign frc_act = (frc_i != FRC_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                m_q <= 1'b0;
    else if (frc_i == FRC_SET)  m_q <= 1'b1;
    else if (frc_act)           m_q <= 1'b0;
    else if (ph_hi_i)           m_q <= master_next(m_q, j_i, k_i, q_fb_i);
  end

  assign m_o = m_q;

  AST_MASTER_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ph_hi_i && !frc_act) |=> $stable(m_q)); // R2

  AST_CAUGHT_ONE_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_hi_i && !frc_act && !q_fb_i && m_q) |=> m_q); // R5

  AST_CAUGHT_ZERO_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_hi_i && !frc_act && q_fb_i && !m_q) |=> !m_q); // R5
endmodule

// File: rtl/jkms_slave.sv
module jkms_slave
  import jkms_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ph_hi_i,
  input  logic m_i,
  input  frc_e frc_i,
  output logic s_o
);
  logic s_q;
  logic frc_act;

  assign frc_act = (frc_i != FRC_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                s_q <= 1'b0;
    else if (frc_i == FRC_SET)  s_q <= 1'b1;
    else if (frc_act)           s_q <= 1'b0;
    else if (!ph_hi_i)          s_q <= m_i;
  end

  assign s_o = s_q;

  AST_SLAVE_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_hi_i && !frc_act) |=> $stable(s_q)); // R3

  AST_SLAVE_FOLLOWS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ph_hi_i && !frc_act) |=> s_q == $past(m_i)); // R4
endmodule

// File: rtl/jkms_emu.sv
module jkms_emu
  import jkms_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic j_i,
  input  logic k_i,
  input  logic ck_i,
  input  logic pr_ni,
  input  logic clr_ni,
  output logic q_o,
  output logic qn_o,
  output logic forbid_o
);
  logic ck_s;
  logic m_state;
  logic s_state;
  frc_e frc;

  assign frc = frc_decode(pr_ni, clr_ni);

  jkms_ck_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ck_i   (ck_i),
    .ck_s_o (ck_s)
  );

  jkms_master u_master (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ph_hi_i (ck_s),
    .j_i     (j_i),
    .k_i     (k_i),
    .q_fb_i  (s_state),
    .frc_i   (frc),
    .m_o     (m_state)
  );

  jkms_slave u_slave (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ph_hi_i (ck_s),
    .m_i     (m_state),
    .frc_i   (frc),
    .s_o     (s_state)
  );

  always_comb begin
    case (frc)
      FRC_SET:  begin q_o = 1'b1;    qn_o = 1'b0;     end
      FRC_CLR:  begin q_o = 1'b0;    qn_o = 1'b1;     end
      FRC_BOTH: begin q_o = 1'b1;    qn_o = 1'b1;     end
      default:  begin q_o = s_state; qn_o = ~s_state; end
    endcase
  end

  assign forbid_o = (frc == FRC_BOTH);

  AST_PRESET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pr_ni && clr_ni) |-> (q_o && !qn_o)); // R6

  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pr_ni && !clr_ni) |-> (!q_o && qn_o)); // R7

  AST_BOTH_LOW_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pr_ni && !clr_ni) |=> (!s_state && !m_state)); // R8

  AST_OUT_COMPLEMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pr_ni && clr_ni) |-> (q_o != qn_o && !forbid_o)); // R1
endmodule

// File: tb/jkms_emu_test.sv
module jkms_emu_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic j = 1'b0, k = 1'b0, ck = 1'b0, pr_n = 1'b1, clr_n = 1'b1;
  logic q, qn, forbid;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic qm;   // bench model of Q

  always #2 clk = ~clk; // 250 MHz

  jkms_emu #(.SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .j_i(j), .k_i(k), .ck_i(ck),
    .pr_ni(pr_n), .clr_ni(clr_n), .q_o(q), .qn_o(qn), .forbid_o(forbid)
  );

  function automatic logic pulse_result(logic q0, logic jj, logic kk);
    return q0 ? ~kk : jj;
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b (q,qn,forbid)", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one device-clock pulse; glitches are OR-ed onto J/K for a single cycle
  task automatic pulse(input logic jj, input logic kk, input logic gj,
                       input logic gk, input int hi_len, input string req);
    logic q0;
    q0 = qm;
    j = jj; k = kk;
    step(1);
    ck = 1'b1;
    step(3);
    if (gj || gk) begin
      j = jj | gj; k = kk | gk;
      step(1);
      j = jj; k = kk;
    end
    step(hi_len);
    #1 check({"R3 ", req}, {q, qn, forbid}, {q0, ~q0, 1'b0});
    step(0);
    @(negedge clk);
    ck = 1'b0;
    step(2);
    #1 check({"R9 ", req}, {q, qn, forbid}, {q0, ~q0, 1'b0});
    qm = pulse_result(q0, jj | gj, kk | gk);
    step(1);
    #1 check(req, {q, qn, forbid}, {qm, ~qm, 1'b0});
    step(2);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    qm = 1'b0;
    step(2);
    #1 check("R1 in reset", {q, qn, forbid}, 3'b010);
    rst_n = 1'b1;
    step(3);
    #1 check("R1 after reset", {q, qn, forbid}, 3'b010);

    // R4 rules
    pulse(1, 0, 0, 0, 2, "R4 set");
    pulse(0, 0, 0, 0, 2, "R4 hold");
    pulse(0, 1, 0, 0, 2, "R4 reset");
    pulse(1, 1, 0, 0, 2, "R4 toggle");
    pulse(1, 1, 0, 0, 20, "R4 long toggle once");
    pulse(1, 1, 0, 0, 20, "R4 long toggle back");

    // R2: activity while CK low is ignored
    for (int i = 0; i < 8; i++) begin
      j = 1'($urandom); k = 1'($urandom);
      step(1);
    end
    #1 check("R2 low phase J/K", {q, qn, forbid}, {qm, ~qm, 1'b0});
    pulse(0, 0, 0, 0, 2, "R2 master untouched");

    // R5 ones catching
    pulse(0, 1, 0, 0, 1, "R5 prep zero");
    pulse(0, 0, 1, 0, 2, "R5 J glitch caught");
    pulse(0, 0, 0, 1, 2, "R5 K glitch caught");
    pulse(0, 0, 0, 1, 2, "R5 K glitch ignored at Q0");
    pulse(1, 0, 0, 0, 1, "R5 prep one");
    pulse(0, 0, 1, 0, 2, "R5 J glitch ignored at Q1");

    // R6 preset
    j = 1'b0; k = 1'b1; pr_n = 1'b0;
    #1 check("R6 preset immediate", {q, qn, forbid}, 3'b100);
    ck = 1'b1; step(6); ck = 1'b0; step(6);
    #1 check("R6 preset over pulse", {q, qn, forbid}, 3'b100);
    pr_n = 1'b1; qm = 1'b1;
    step(1);
    #1 check("R6 holds after release", {q, qn, forbid}, 3'b100);
    pulse(0, 0, 0, 0, 2, "R6 state kept");

    // R7 clear
    j = 1'b1; k = 1'b0; clr_n = 1'b0;
    #1 check("R7 clear immediate", {q, qn, forbid}, 3'b010);
    ck = 1'b1; step(6); ck = 1'b0; step(6);
    #1 check("R7 clear over pulse", {q, qn, forbid}, 3'b010);
    clr_n = 1'b1; qm = 1'b0;
    pulse(0, 0, 0, 0, 2, "R7 state kept");

    // R8 forbidden combination
    pulse(1, 0, 0, 0, 2, "R8 prep one");
    pr_n = 1'b0; clr_n = 1'b0;
    #1 check("R8 both low", {q, qn, forbid}, 3'b111);
    step(2);
    pr_n = 1'b1; clr_n = 1'b1; qm = 1'b0;
    #1 check("R8 release to zero", {q, qn, forbid}, 3'b010);
    pulse(0, 0, 0, 0, 2, "R8 zero kept");

    // random pulses with occasional glitches
    for (int n = 0; n < 80; n++) begin
      logic rj, rk, gj, gk;
      rj = 1'($urandom); rk = 1'($urandom);
      gj = (($urandom % 4) == 0); gk = (($urandom % 4) == 0);
      pulse(rj, rk, gj, gk, 1 + ($urandom % 6), "R4/R5 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule